// File: doc/BRIEF.md
# Sound Channel Register Decoder

This block sits between a host write bus and the playback engine of a 64-voice sample player. The host writes 16-bit values into two address windows, one for voices 0 to 31 and one for voices 32 to 63. The decoder works out which voice and which parameter slot each write is aimed at. It then stores the value in a form the engine can use directly: a 21-bit start address, a loop enable, a decoded sample format, loop begin and end points, a sample rate in samples per second, a pan position and a volume gain.

Two slots need conversion before they are stored. The pitch word is a small floating-point number, and it is turned into a rate around a base of 44100. The volume index passes through a square-law curve. A write to the configuration slot can also carry a global trigger. When it does, the decoder latches the key bit of every voice into the running mask in the same cycle.

On the read side, a selected-voice register picks one voice. The host can then read that voice's loop-reached status, which clears when it is read, or its current playback position. The engine reports both of these to the decoder. Each voice's stored parameters appear on a query port addressed by voice number.

Top module: `sndch_regdec`

## Requirements
- R1: A write selects voice `wr_bank*32 + wr_addr[11:7]` and slot `wr_addr[6:0]`. It updates only that voice.
- R2: A write to slot 0x00 stores three fields. `wr_data[4:0]` becomes start bits [20:16], and `wr_data[9]` becomes the loop enable. `wr_data[8:7]` sets the format as follows: 0 gives code 0 (16-bit), 1 gives code 1 (8-bit), and 2 or 3 give code 2 (ADPCM).
- R3: Slot 0x04 stores start bits [15:0], slot 0x08 stores the loop begin point and slot 0x0C stores the loop end point. Each takes the full 16 bits.
- R4: A write to slot 0x00 stores `wr_data[14]` as that voice's key bit. If `wr_data[15]` is also 1, then after that clock `key_on` equals the key bits of all voices, including the bit just written. Without a trigger, `key_on` does not change.
- R5: A pitch word at slot 0x18 has sign bit 14, field f = bits [13:11] and mantissa m = bits [9:0]; bit 10 has no effect. With sign 0 and e = f, the rate is (44100<<e) + ((44100·m)>>(10-e)). With sign 1 and e = 8-f, the rate is (44100>>e) + ((44100·m)>>(10+e)). The rate appears on the query port one clock after the write's clock edge.
- R6: For slot 0x24, pan = 15-v when v = `wr_data[4:0]` is at most 15, and pan = v otherwise.
- R7: For slot 0x28, volume = (i·i+255)>>8, where i = `wr_data[7:0]`. This curve rises monotonically from 0 to 255.
- R8: `sel_wr_en` loads the selected voice. A `loop_hit` pulse sets that voice's loop flag. A state read returns 0x8000 on `rd_data` if the selected voice's flag is set and 0 otherwise, and clears the flag. A hit in the same clock as the read keeps the flag set.
- R9: A position read returns the selected voice's 16-bit slice of `pos_in` on `rd_data` after the clock.
- R10: Writes to any other slot (for example 0x10 or 0x1C) change no stored parameter and no key bit.
- R11: After reset, every stored parameter, key bit, loop flag, `key_on` and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Parameter write strobe |
| wr_bank | input | 1 | Window select: 0 for voices 0-31, 1 for voices 32-63 |
| wr_addr | input | 12 | Byte address within the window |
| wr_data | input | 16 | Write data lane |
| sel_wr_en | input | 1 | Load the selected-voice register |
| sel_chan | input | 6 | Voice number for the selected-voice register |
| rd_state_en | input | 1 | Read loop status of the selected voice (clears it) |
| rd_pos_en | input | 1 | Read position of the selected voice |
| rd_data | output | 16 | Registered read result |
| loop_hit | input | 64 | Per-voice loop-reached pulses from the engine |
| pos_in | input | 1024 | Per-voice 16-bit positions from the engine, voice n at bits [16n+15:16n] |
| key_on | output | 64 | Running mask latched by the global trigger |
| q_chan | input | 6 | Voice to show on the query outputs |
| q_start | output | 21 | Start address of the queried voice |
| q_loop_en | output | 1 | Loop enable of the queried voice |
| q_fmt | output | 2 | Format code of the queried voice |
| q_loop_beg | output | 16 | Loop begin point of the queried voice |
| q_loop_end | output | 16 | Loop end point of the queried voice |
| q_rate | output | 24 | Sample rate of the queried voice |
| q_pan | output | 5 | Pan of the queried voice |
| q_vol | output | 8 | Volume of the queried voice |

## Verification
The assertions assume that `loop_hit` is a set of single-cycle pulses. They also assume that `rd_state_en` and `rd_pos_en` are never raised in the same cycle, so each read returns only one kind of value. The bench drives every strobe for exactly one clock and issues one read at a time. It raises `loop_hit` only in cycles that have no state read, except for the one test that deliberately collides a hit with a read. The trigger checks assume that the write bus carries no more than one write per clock, and the bench keeps to that.

// File: rtl/sndch_pkg.sv
// Shared constants, types and small conversion functions for the sound
// channel register decoder. Assumes a 16-bit write data lane.
package sndch_pkg;

    localparam int BASE_RATE = 44100;

    // Slot offsets inside one voice's 128-byte register window.
    localparam logic [6:0] SLOT_CFG      = 7'h00;
    localparam logic [6:0] SLOT_START_LO = 7'h04;
    localparam logic [6:0] SLOT_LOOP_BEG = 7'h08;
    localparam logic [6:0] SLOT_LOOP_END = 7'h0C;
    localparam logic [6:0] SLOT_PITCH    = 7'h18;
    localparam logic [6:0] SLOT_PAN      = 7'h24;
    localparam logic [6:0] SLOT_VOL      = 7'h28;

    typedef enum logic [1:0] {
        FMT_PCM16 = 2'd0,
        FMT_PCM8  = 2'd1,
        FMT_ADPCM = 2'd2
    } fmt_e;

    // Map the two raw format bits onto the stored format code.
    function automatic fmt_e fmt_decode(input logic [1:0] raw);
        case (raw)
            2'd0:    fmt_decode = FMT_PCM16;
            2'd1:    fmt_decode = FMT_PCM8;
            default: fmt_decode = FMT_ADPCM;
        endcase
    endfunction

    // Fold the lower half of the pan range so the scale runs smoothly.
    function automatic logic [4:0] pan_map(input logic [4:0] raw);
        pan_map = raw[4] ? raw : (5'd15 - raw);
    endfunction

endpackage

// File: rtl/sndch_rate_conv.sv
// Pitch-word to sample-rate converter, one register stage.
// Captures the pitch word for a voice on a write edge. The rate is
// computed from the captured word and offered with out_valid during the
// following cycle, so the parent stores it on the next edge.
// Assumes the pitch word arrives as {sign, field[2:0], mantissa[9:0]}.
module sndch_rate_conv
    import sndch_pkg::*;
#(
    parameter int CH_W   = 6,
    parameter int RATE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CH_W-1:0]   in_ch,
    input  logic [13:0]       in_pitch,
    output logic              out_valid,
    output logic [CH_W-1:0]   out_ch,
    output logic [RATE_W-1:0] out_rate
);
    localparam logic [31:0] BASE = 32'(BASE_RATE);

    logic [13:0] pitch_q;

    // Stage register: hold the pending voice and pitch word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_ch    <= '0;
            pitch_q   <= '0;
        end else begin
            out_valid <= in_valid;
            out_ch    <= in_ch;
            pitch_q   <= in_pitch;
        end
    end

    logic        sgn;
    logic [2:0]  fld;
    logic [9:0]  man;
    logic [3:0]  shamt;
    logic [31:0] prod;
    logic [31:0] whole;
    logic [31:0] frac;

    // Exponent-scaled base plus mantissa fraction.
    always_comb begin
        sgn   = pitch_q[13];
        fld   = pitch_q[12:10];
        man   = pitch_q[9:0];
        prod  = BASE * {22'd0, man};
        if (sgn) begin
            shamt = 4'd8 - {1'b0, fld};
            whole = BASE >> shamt;
            frac  = prod >> (5'd10 + {1'b0, shamt});
        end else begin
            shamt = {1'b0, fld};
            whole = BASE << shamt;
            frac  = prod >> (5'd10 - {1'b0, shamt});
        end
        out_rate = RATE_W'(whole + frac);
    end

endmodule

// File: rtl/sndch_vol_map.sv
// Volume curve: square-law map of an 8-bit index onto an 8-bit gain,
// gain = (i*i + 255) >> 8, monotonic from 0 to 255. Purely combinational.
module sndch_vol_map #(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] gain
);
    localparam int SQ_W = 2 * IDX_W + 1;
    localparam logic [SQ_W-1:0] ROUND = SQ_W'((1 << IDX_W) - 1);

    logic [SQ_W-1:0] sq;

    // Square and round up, then keep the top byte.
    always_comb begin
        sq   = SQ_W'(idx) * SQ_W'(idx) + ROUND;
        gain = sq[IDX_W +: IDX_W];
    end

endmodule

// File: rtl/sndch_loop_flags.sv
// Per-voice loop-reached flags. A hit pulse sets a flag, and a clear
// request for one voice resets it. A set in the same cycle wins.
module sndch_loop_flags #(
    parameter int NUM_CH = 64,
    parameter int CH_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] hit,
    input  logic              clr_en,
    input  logic [CH_W-1:0]   clr_ch,
    output logic [NUM_CH-1:0] flags
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_flag
        // One flag: set on hit, clear on a matching read.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[g] <= 1'b0;
            else if (hit[g])
                flags[g] <= 1'b1;
            else if (clr_en && (clr_ch == CH_W'(g)))
                flags[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/sndch_regdec.sv
// Sound channel register decoder (top).
// Decodes 16-bit writes into per-voice playback parameters and converts
// the pitch and volume slots. It applies the global key trigger and serves
// the selected-voice status and position reads.
// Assumes one write per clock and single-cycle strobes.
module sndch_regdec
    import sndch_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter int POS_W  = 16,
    parameter int RATE_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_bank,
    input  logic [11:0]             wr_addr,
    input  logic [15:0]             wr_data,
    input  logic                    sel_wr_en,
    input  logic [$clog2(NUM_CH)-1:0] sel_chan,
    input  logic                    rd_state_en,
    input  logic                    rd_pos_en,
    output logic [15:0]             rd_data,
    input  logic [NUM_CH-1:0]       loop_hit,
    input  logic [NUM_CH*POS_W-1:0] pos_in,
    output logic [NUM_CH-1:0]       key_on,
    input  logic [$clog2(NUM_CH)-1:0] q_chan,
    output logic [20:0]             q_start,
    output logic                    q_loop_en,
    output logic [1:0]              q_fmt,
    output logic [15:0]             q_loop_beg,
    output logic [15:0]             q_loop_end,
    output logic [RATE_W-1:0]       q_rate,
    output logic [4:0]              q_pan,
    output logic [7:0]              q_vol
);
    localparam int CH_W  = $clog2(NUM_CH);
    localparam int WIN_W = CH_W - 1;

    // Per-voice parameter storage.
    logic [20:0]       start_q    [NUM_CH];
    logic              loop_en_q  [NUM_CH];
    fmt_e              fmt_q      [NUM_CH];
    logic [15:0]       loop_beg_q [NUM_CH];
    logic [15:0]       loop_end_q [NUM_CH];
    logic [RATE_W-1:0] rate_q     [NUM_CH];
    logic [4:0]        pan_q      [NUM_CH];
    logic [7:0]        vol_q      [NUM_CH];
    logic [NUM_CH-1:0] key_bit_q;

    logic [CH_W-1:0] wr_ch;
    logic [6:0]      wr_slot;
    logic            wr_cfg;
    logic            wr_pitch;

    // Address split into voice number and slot.
    always_comb begin
        wr_ch    = {wr_bank, wr_addr[11:7]};
        wr_slot  = wr_addr[6:0];
        wr_cfg   = wr_en && (wr_slot == SLOT_CFG);
        wr_pitch = wr_en && (wr_slot == SLOT_PITCH);
    end

    logic              rc_valid;
    logic [CH_W-1:0]   rc_ch;
    logic [RATE_W-1:0] rc_rate;

    sndch_rate_conv #(.CH_W(CH_W), .RATE_W(RATE_W)) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (wr_pitch),
        .in_ch    (wr_ch),
        .in_pitch ({wr_data[14:11], wr_data[9:0]}),
        .out_valid(rc_valid),
        .out_ch   (rc_ch),
        .out_rate (rc_rate)
    );

    logic [7:0] vol_gain;

    sndch_vol_map #(.IDX_W(8)) u_vol (
        .idx (wr_data[7:0]),
        .gain(vol_gain)
    );

    // Parameter slot writes, plus the delayed rate store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                start_q[i]    <= '0;
                loop_en_q[i]  <= 1'b0;
                fmt_q[i]      <= FMT_PCM16;
                loop_beg_q[i] <= '0;
                loop_end_q[i] <= '0;
                rate_q[i]     <= '0;
                pan_q[i]      <= '0;
                vol_q[i]      <= '0;
            end
        end else begin
            if (wr_en) begin
                case (wr_slot)
                    SLOT_CFG: begin
                        start_q[wr_ch][20:16] <= wr_data[4:0];
                        loop_en_q[wr_ch]      <= wr_data[9];
                        fmt_q[wr_ch]          <= fmt_decode(wr_data[8:7]);
                    end
                    SLOT_START_LO: start_q[wr_ch][15:0] <= wr_data;
                    SLOT_LOOP_BEG: loop_beg_q[wr_ch]    <= wr_data;
                    SLOT_LOOP_END: loop_end_q[wr_ch]    <= wr_data;
                    SLOT_PAN:      pan_q[wr_ch]         <= pan_map(wr_data[4:0]);
                    SLOT_VOL:      vol_q[wr_ch]         <= vol_gain;
                    default: ;
                endcase
            end
            if (rc_valid)
                rate_q[rc_ch] <= rc_rate;
        end
    end

    // Key bits and the global trigger that latches them all at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_bit_q <= '0;
            key_on    <= '0;
        end else if (wr_cfg) begin
            key_bit_q[wr_ch] <= wr_data[14];
            if (wr_data[15]) begin
                for (int i = 0; i < NUM_CH; i++)
                    key_on[i] <= (CH_W'(i) == wr_ch) ? wr_data[14] : key_bit_q[i];
            end
        end
    end

    logic [CH_W-1:0]   sel_q;
    logic [NUM_CH-1:0] lp_flags;

    // Selected-voice register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (sel_wr_en)
            sel_q <= sel_chan;
    end

    sndch_loop_flags #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (loop_hit),
        .clr_en(rd_state_en),
        .clr_ch(sel_q),
        .flags (lp_flags)
    );

    // Registered read port: loop status first, then position.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_state_en)
            rd_data <= lp_flags[sel_q] ? 16'h8000 : 16'h0000;
        else if (rd_pos_en)
            rd_data <= pos_in[sel_q*POS_W +: 16];
    end

    // Query port: stored state of one voice.
    always_comb begin
        q_start    = start_q[q_chan];
        q_loop_en  = loop_en_q[q_chan];
        q_fmt      = fmt_q[q_chan];
        q_loop_beg = loop_beg_q[q_chan];
        q_loop_end = loop_end_q[q_chan];
        q_rate     = rate_q[q_chan];
        q_pan      = pan_q[q_chan];
        q_vol      = vol_q[q_chan];
    end

    logic unused_win;
    assign unused_win = (WIN_W > 0);

endmodule

// File: rtl/sndch_regdec_chk.sv
// Assertion checker for the sound channel register decoder, bound to the
// top. Assumes single-cycle strobes and pulses on the inputs.
module sndch_regdec_chk #(
    parameter int NUM_CH = 64,
    parameter int CH_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_bank,
    input logic [11:0]       wr_addr,
    input logic [1:0]        key_ctl,
    input logic              rd_state_en,
    input logic [15:0]       rd_data,
    input logic [NUM_CH-1:0] loop_hit,
    input logic [NUM_CH-1:0] key_on,
    input logic [NUM_CH-1:0] loop_flags,
    input logic [CH_W-1:0]   sel_q
);
    logic            trig;
    logic            trig_d;
    logic            bit_d;
    logic [CH_W-1:0] ch_d;
    logic            clr_d;
    logic [CH_W-1:0] sel_d;

    assign trig = wr_en && (wr_addr[6:0] == 7'h00) && key_ctl[1];

    // Remember the trigger and the read target for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_d <= 1'b0;
            bit_d  <= 1'b0;
            ch_d   <= '0;
            clr_d  <= 1'b0;
            sel_d  <= '0;
        end else begin
            trig_d <= trig;
            bit_d  <= key_ctl[0];
            ch_d   <= {wr_bank, wr_addr[11:7]};
            clr_d  <= rd_state_en && !loop_hit[sel_q];
            sel_d  <= sel_q;
        end
    end

    // R4: the triggering voice's own new key bit reaches the mask.
    p_trig_own_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trig_d |-> (key_on[ch_d] == bit_d));

    // R4: without a trigger the mask holds.
    p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !trig |=> $stable(key_on));

    // R8: a hit pulse leaves its flag set.
    p_hit_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_hit != '0) |=> ((loop_flags & $past(loop_hit)) == $past(loop_hit)));

    // R8: a status read without a colliding hit clears the flag.
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_d |-> !loop_flags[sel_d]);

    // R8: a status read returns only one of the two status codes.
    p_state_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_state_en |=> (rd_data == 16'h0000 || rd_data == 16'h8000));

endmodule

bind sndch_regdec sndch_regdec_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_bank    (wr_bank),
    .wr_addr    (wr_addr),
    .key_ctl    (wr_data[15:14]),
    .rd_state_en(rd_state_en),
    .rd_data    (rd_data),
    .loop_hit   (loop_hit),
    .key_on     (key_on),
    .loop_flags (lp_flags),
    .sel_q      (sel_q)
);

// File: tb/sndch_regdec_test.sv
// Self-checking bench for the sound channel register decoder.
module sndch_regdec_test;
    localparam int NUM_CH = 64;
    localparam int POS_W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_bank = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic sel_wr_en = 1'b0;
    logic [5:0] sel_chan = '0;
    logic rd_state_en = 1'b0, rd_pos_en = 1'b0;
    logic [15:0] rd_data;
    logic [NUM_CH-1:0] loop_hit = '0;
    logic [NUM_CH*POS_W-1:0] pos_in = '0;
    logic [NUM_CH-1:0] key_on;
    logic [5:0] q_chan = '0;
    logic [20:0] q_start;
    logic q_loop_en;
    logic [1:0] q_fmt;
    logic [15:0] q_loop_beg, q_loop_end;
    logic [23:0] q_rate;
    logic [4:0] q_pan;
    logic [7:0] q_vol;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sndch_regdec uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_addr(wr_addr), .wr_data(wr_data), .sel_wr_en(sel_wr_en),
        .sel_chan(sel_chan), .rd_state_en(rd_state_en), .rd_pos_en(rd_pos_en),
        .rd_data(rd_data), .loop_hit(loop_hit), .pos_in(pos_in),
        .key_on(key_on), .q_chan(q_chan), .q_start(q_start),
        .q_loop_en(q_loop_en), .q_fmt(q_fmt), .q_loop_beg(q_loop_beg),
        .q_loop_end(q_loop_end), .q_rate(q_rate), .q_pan(q_pan), .q_vol(q_vol)
    );

    // Pitch word and expected rate, packed {pitch[15:0], rate[23:0]}.
    localparam logic [39:0] RATE_VEC [10] = '{
        {16'h0000, 24'd44100},
        {16'h0200, 24'd66150},
        {16'h0800, 24'd88200},
        {16'h3BFF, 24'd11284087},
        {16'h4000, 24'd172},
        {16'h7800, 24'd22050},
        {16'h7A00, 24'd33075},
        {16'h0400, 24'd44100},
        {16'h4001, 24'd172},
        {16'h43FF, 24'd344}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int ch, input logic [6:0] slot, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_bank = (ch >= 32);
        wr_addr = {ch[4:0], slot}; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sel(input int ch);
        @(negedge clk);
        sel_wr_en = 1'b1; sel_chan = ch[5:0];
        @(negedge clk);
        sel_wr_en = 1'b0;
    endtask

    task automatic rd(input logic state);
        @(negedge clk);
        rd_state_en = state; rd_pos_en = !state;
        @(negedge clk);
        rd_state_en = 1'b0; rd_pos_en = 1'b0;
    endtask

    task automatic look(input int ch);
        q_chan = ch[5:0];
        #1;
    endtask

    initial begin : watchdog
        #2000000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        look(9);
        check("R11 start", q_start, 0);
        check("R11 rate", q_rate, 0);
        check("R11 key_on", key_on, 0);
        check("R11 rd_data", rd_data, 0);

        // R5: rate table walk, voice varies with index
        for (int k = 0; k < 10; k++) begin
            wr(k * 6, 7'h18, RATE_VEC[k][39:24]);
            look(k * 6);
            check("R5 rate one cycle late", q_rate, 0);
            @(negedge clk); #1;
            check("R5 rate", q_rate, RATE_VEC[k][23:0]);
        end

        // R2: config fields and format decode
        wr(3, 7'h00, 16'h0215);
        look(3);
        check("R2 start hi", q_start, 21'h150000);
        check("R2 loop en", q_loop_en, 1);
        check("R2 fmt 16bit", q_fmt, 0);
        wr(3, 7'h00, 16'h0080);
        check("R2 fmt 8bit", q_fmt, 1);
        check("R2 loop off", q_loop_en, 0);
        wr(3, 7'h00, 16'h0180);
        check("R2 fmt raw3 adpcm", q_fmt, 2);
        wr(3, 7'h00, 16'h0100);
        check("R2 fmt raw2 adpcm", q_fmt, 2);

        // R3 and R1: address slots, upper window
        wr(37, 7'h04, 16'hBEEF);
        wr(37, 7'h08, 16'h1111);
        wr(37, 7'h0C, 16'hFFFE);
        look(37);
        check("R3 start lo", q_start, 21'h00BEEF);
        check("R3 loop beg", q_loop_beg, 16'h1111);
        check("R3 loop end", q_loop_end, 16'hFFFE);
        look(5);
        check("R1 window separation", q_start, 0);

        // R6: pan folding
        wr(7, 7'h24, 16'h0003); look(7); check("R6 pan 3", q_pan, 12);
        wr(7, 7'h24, 16'h0014); check("R6 pan 20", q_pan, 20);
        wr(7, 7'h24, 16'h000F); check("R6 pan 15", q_pan, 0);
        wr(7, 7'h24, 16'hFFF0); check("R6 pan 16 high bits", q_pan, 16);

        // R7: volume curve
        wr(8, 7'h28, 16'h0000); look(8); check("R7 vol 0", q_vol, 0);
        wr(8, 7'h28, 16'h000F); check("R7 vol 15", q_vol, 1);
        wr(8, 7'h28, 16'h0080); check("R7 vol 128", q_vol, 64);
        wr(8, 7'h28, 16'hAAFF); check("R7 vol 255", q_vol, 255);

        // R10: unlisted slots leave voice 37 untouched
        wr(37, 7'h10, 16'h4321);
        wr(37, 7'h1C, 16'hC000);
        look(37);
        check("R10 start kept", q_start, 21'h00BEEF);
        check("R10 loop beg kept", q_loop_beg, 16'h1111);
        check("R10 pan kept", q_pan, 0);
        check("R10 key_on kept", key_on, 0);

        // R4: arm voices 2 and 40, then trigger from voice 5 with its bit low
        wr(2, 7'h00, 16'h4000);
        wr(40, 7'h00, 16'h4000);
        check("R4 no trigger yet", key_on, 0);
        wr(5, 7'h00, 16'h8000);
        check("R4 trigger mask", key_on, (64'd1 << 2) | (64'd1 << 40));
        wr(2, 7'h00, 16'hC000);
        check("R4 trigger with own bit", key_on, (64'd1 << 2) | (64'd1 << 40));
        wr(40, 7'h00, 16'h8000);
        check("R4 trigger drops own bit", key_on, 64'd1 << 2);

        // R8: loop flag set, read, clear
        sel(40);
        rd(1'b1);
        check("R8 no flag", rd_data, 16'h0000);
        @(negedge clk); loop_hit[40] = 1'b1;
        @(negedge clk); loop_hit[40] = 1'b0;
        rd(1'b1);
        check("R8 flag read", rd_data, 16'h8000);
        rd(1'b1);
        check("R8 cleared by read", rd_data, 16'h0000);
        // R8: hit in the same cycle as a read keeps the flag
        @(negedge clk); loop_hit[40] = 1'b1; rd_state_en = 1'b1;
        @(negedge clk); loop_hit[40] = 1'b0; rd_state_en = 1'b0;
        rd(1'b1);
        check("R8 set wins", rd_data, 16'h8000);

        // R9: position readback of the selected voice
        pos_in[40*POS_W +: 16] = 16'h1234;
        pos_in[41*POS_W +: 16] = 16'h9999;
        rd(1'b0);
        check("R9 pos 40", rd_data, 16'h1234);
        sel(41);
        rd(1'b0);
        check("R9 pos 41", rd_data, 16'h9999);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule